// File: doc/BRIEF.md
# DRAM Command Spacing Monitor

This block observes a DRAM command stream one slot per clock. Each slot holds no command, an activate, a read, a write or a precharge, together with a bank number. For every command it checks two things. First, that the command fits the bank's open or closed state. Second, that enough clock cycles have passed since the earlier commands that constrain it, on the same bank or across the device. It reports the first broken rule as a small code in the same cycle as the offending command.

Every timing limit is a static configuration input counted in clock cycles. The row cycle limit is not a separate input: it is the active time plus the precharge time.

A read that breaks no rule is accepted. It is followed, exactly CAS-latency cycles later, by a one-cycle strobe that predicts when read data will appear. Commands always update the bank state, whether or not they are flagged.

Command encoding on `cmd`: 0 = none, 1 = activate, 2 = read, 3 = write, 4 = precharge.

"d cycles apart" means that a command presented in cycle t is followed by another in cycle t+d. A rule with limit N is broken when d < N.

Top module: `dram_timing_monitor`

## Requirements
- R1: `viol` is high exactly when `viol_code` is nonzero. A cycle with no command always shows code 0. Codes are: 1 protocol, 2 activate-to-column, 3 activate-to-precharge, 4 precharge-to-activate, 5 row cycle, 6 activate-to-activate across banks, 7 write recovery, 8 write-to-read.
- R2: A read with code 0 raises `rd_valid` for one cycle, exactly `cfg_cl` cycles after it (`cfg_cl` from 1 to MAX_CL). A read that breaks a rule raises no strobe.
- R3: A read or write to a closed bank, or an activate to an open bank, gives code 1. A precharge to a closed bank is legal and closes nothing new.
- R4: A read or write less than `cfg_trcd` cycles after that bank's activate gives code 2.
- R5: A precharge less than `cfg_tras` cycles after that bank's activate gives code 3.
- R6: An activate less than `cfg_trp` cycles after that bank's precharge gives code 4.
- R7: An activate less than `cfg_tras + cfg_trp` cycles after the previous activate to the same bank gives code 5.
- R8: An activate to a bank other than the one most recently activated, less than `cfg_trrd` cycles after that activate, gives code 6.
- R9: The last write data to a bank is taken to occur `cfg_wlbl` cycles after the write command. A precharge to that bank less than `cfg_twr` cycles after that point gives code 7.
- R10: A read to any bank less than `cfg_twtr` cycles after the last write data of the device (write command plus `cfg_wlbl`) gives code 8.
- R11: When several rules fail in one cycle, the lowest code is reported.
- R12: Synchronous active-high `rst` closes every bank and leaves no timing rule pending. The first activate after reset is legal to any bank, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command slot (0 none, 1 act, 2 read, 3 write, 4 pre) |
| bank | input | $clog2(NBANKS) | Bank addressed by the command |
| cfg_cl | input | $clog2(MAX_CL+1) | CAS latency in cycles |
| cfg_trcd | input | CW | Activate to read/write |
| cfg_tras | input | CW | Activate to precharge |
| cfg_trp | input | CW | Precharge to activate |
| cfg_trrd | input | CW | Activate to activate on different banks |
| cfg_twr | input | CW | Last write data to precharge |
| cfg_twtr | input | CW | Last write data to read |
| cfg_wlbl | input | CW | Write command to last write data |
| viol | output | 1 | Current command breaks a rule |
| viol_code | output | 4 | Lowest-numbered broken rule, 0 if none |
| rd_valid | output | 1 | Predicted read data strobe |

## Verification
Precharge-to-activate spacing and row-cycle spacing can fail on the same activate. The bench provokes this by issuing an activate one cycle after a legal precharge, which is also well inside the row cycle. It then requires code 4 rather than 5. A second scenario makes the row cycle fail alone: it precharges too early, then waits out the precharge time. That shows the two rules are separately decoded and not merely ordered.

// File: rtl/dram_timing_monitor.sv
module dram_timing_monitor #(
  parameter int NBANKS = 4,
  parameter int CW = 6,
  parameter int MAX_CL = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [2:0]                    cmd,
  input  logic [$clog2(NBANKS)-1:0]     bank,
  input  logic [$clog2(MAX_CL+1)-1:0]   cfg_cl,
  input  logic [CW-1:0]                 cfg_trcd,
  input  logic [CW-1:0]                 cfg_tras,
  input  logic [CW-1:0]                 cfg_trp,
  input  logic [CW-1:0]                 cfg_trrd,
  input  logic [CW-1:0]                 cfg_twr,
  input  logic [CW-1:0]                 cfg_twtr,
  input  logic [CW-1:0]                 cfg_wlbl,
  output logic                          viol,
  output logic [3:0]                    viol_code,
  output logic                          rd_valid
);
  localparam int BW  = $clog2(NBANKS);
  localparam int CLW = $clog2(MAX_CL+1);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [NBANKS-1:0] open_q;
  logic [CW-1:0]     act_age [NBANKS];
  logic [CW-1:0]     pre_age [NBANKS];
  logic [CW-1:0]     wr_age  [NBANKS];
  logic [CW-1:0]     gact_age, gwr_age;
  logic [BW-1:0]     last_act;
  logic [MAX_CL-1:0] rd_sr;

  wire is_act = (cmd == 3'd1);
  wire is_rd  = (cmd == 3'd2);
  wire is_wr  = (cmd == 3'd3);
  wire is_pre = (cmd == 3'd4);

  wire [CW:0] trc_win  = {1'b0, cfg_tras} + {1'b0, cfg_trp};
  wire [CW:0] twr_win  = {1'b0, cfg_wlbl} + {1'b0, cfg_twr};
  wire [CW:0] twtr_win = {1'b0, cfg_wlbl} + {1'b0, cfg_twtr};

  wire [CW-1:0] a_age = act_age[bank];
  wire [CW-1:0] p_age = pre_age[bank];
  wire [CW-1:0] w_age = wr_age[bank];

  wire f_proto = ((is_rd | is_wr) & ~open_q[bank]) | (is_act & open_q[bank]);
  wire f_rcd   = (is_rd | is_wr) & (a_age < cfg_trcd);
  wire f_ras   = is_pre & (a_age < cfg_tras);
  wire f_rp    = is_act & (p_age < cfg_trp);
  wire f_rc    = is_act & ({1'b0, a_age} < trc_win);
  wire f_rrd   = is_act & (last_act != bank) & (gact_age < cfg_trrd);
  wire f_wr    = is_pre & ({1'b0, w_age} < twr_win);
  wire f_wtr   = is_rd & ({1'b0, gwr_age} < twtr_win);

  always_comb begin
    if      (f_proto) viol_code = 4'd1;
    else if (f_rcd)   viol_code = 4'd2;
    else if (f_ras)   viol_code = 4'd3;
    else if (f_rp)    viol_code = 4'd4;
    else if (f_rc)    viol_code = 4'd5;
    else if (f_rrd)   viol_code = 4'd6;
    else if (f_wr)    viol_code = 4'd7;
    else if (f_wtr)   viol_code = 4'd8;
    else              viol_code = 4'd0;
  end

  assign viol = |viol_code;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? SAT : v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= '0;
      gact_age <= SAT;
      gwr_age  <= SAT;
      last_act <= '0;
      rd_sr    <= '0;
      for (int b = 0; b < NBANKS; b++) begin
        act_age[b] <= SAT;
        pre_age[b] <= SAT;
        wr_age[b]  <= SAT;
      end
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        act_age[b] <= (is_act && bank == BW'(b)) ? ONE : bump(act_age[b]);
        pre_age[b] <= (is_pre && bank == BW'(b)) ? ONE : bump(pre_age[b]);
        wr_age[b]  <= (is_wr  && bank == BW'(b)) ? ONE : bump(wr_age[b]);
        if (is_act && bank == BW'(b)) open_q[b] <= 1'b1;
        else if (is_pre && bank == BW'(b)) open_q[b] <= 1'b0;
      end
      gact_age <= is_act ? ONE : bump(gact_age);
      gwr_age  <= is_wr  ? ONE : bump(gwr_age);
      if (is_act) last_act <= bank;
      rd_sr <= {rd_sr[MAX_CL-2:0], is_rd & ~viol};
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    for (int i = 0; i < MAX_CL; i++)
      if (cfg_cl == CLW'(i + 1)) rd_valid = rd_sr[i];
  end
endmodule

// File: rtl/dram_timing_monitor_chk.sv
module dram_timing_monitor_chk #(
  parameter int NBANKS = 4,
  parameter int CW = 6,
  parameter int MAX_CL = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic [2:0]                  cmd,
  input logic [$clog2(NBANKS)-1:0]   bank,
  input logic [$clog2(MAX_CL+1)-1:0] cfg_cl,
  input logic [CW-1:0]               cfg_twtr,
  input logic [CW-1:0]               cfg_wlbl,
  input logic                        viol,
  input logic [3:0]                  viol_code,
  input logic                        rd_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd0 |-> (viol_code == 4'd0 && !viol)); // R1
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    viol_code <= 4'd8); // R1
  AST_CL1_STROBE: assert property (@(posedge clk) disable iff (rst)
    (cfg_cl == 1 && !$past(rst)) |-> rd_valid == $past(cmd == 3'd2 && !viol)); // R2
  AST_REACT_OPEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cmd == 3'd1 && $past(cmd) == 3'd1 && $past(bank) == bank)
      |-> viol_code == 4'd1); // R3
  AST_WTR_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cmd == 3'd2 && $past(cmd) == 3'd3 &&
     ({1'b0, cfg_wlbl} + {1'b0, cfg_twtr}) > 2) |-> viol_code != 4'd0); // R10
  AST_RESET_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_valid); // R12
endmodule

bind dram_timing_monitor dram_timing_monitor_chk #(
  .NBANKS(NBANKS), .CW(CW), .MAX_CL(MAX_CL)
) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .cfg_cl(cfg_cl),
  .cfg_twtr(cfg_twtr), .cfg_wlbl(cfg_wlbl), .viol(viol),
  .viol_code(viol_code), .rd_valid(rd_valid)
);

// File: tb/dram_timing_monitor_test.sv
module dram_timing_monitor_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic [4:0] cfg_cl = 5'd3;
  logic [5:0] cfg_trcd = 6'd3, cfg_tras = 6'd6, cfg_trp = 6'd3, cfg_trrd = 6'd2;
  logic [5:0] cfg_twr = 6'd3, cfg_twtr = 6'd2, cfg_wlbl = 6'd4;
  logic viol, rd_valid;
  logic [3:0] viol_code;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  always #2.5 clk = ~clk;

  dram_timing_monitor uut (
    .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .cfg_cl(cfg_cl),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trrd(cfg_trrd), .cfg_twr(cfg_twr), .cfg_twtr(cfg_twtr),
    .cfg_wlbl(cfg_wlbl), .viol(viol), .viol_code(viol_code), .rd_valid(rd_valid)
  );

  task automatic issue(input logic [2:0] c, input logic [1:0] b,
                       input logic [3:0] ecode, input logic erv, input string req);
    @(negedge clk);
    cmd = c; bank = b;
    #1;
    checks++;
    if (viol_code !== ecode || viol !== (ecode != 0)) begin
      fails++;
      $display("FAIL %s code: actual %0d/%0b expected %0d", req, viol_code, viol, ecode);
    end
    checks++;
    if (rd_valid !== erv) begin
      fails++;
      $display("FAIL %s rd_valid: actual %0b expected %0b", req, rd_valid, erv);
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) issue(NOP, 2'd0, 4'd0, 1'b0, req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cmd = NOP;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    issue(NOP, 2'd0, 4'd0, 1'b0, "R12");
    issue(ACT, 2'd2, 4'd0, 1'b0, "R12");
    issue(RD,  2'd1, 4'd1, 1'b0, "R12 closed after reset");
  endtask

  task automatic t_proto();
    do_reset();
    issue(RD,  2'd2, 4'd1, 1'b0, "R3");
    issue(WR,  2'd2, 4'd1, 1'b0, "R3");
    issue(ACT, 2'd2, 4'd0, 1'b0, "R3");
    idle(10, "R3");
    issue(ACT, 2'd2, 4'd1, 1'b0, "R3 open");
    issue(PRE, 2'd3, 4'd0, 1'b0, "R3 pre closed");
  endtask

  task automatic t_rcd_cl();
    do_reset();
    issue(ACT, 2'd0, 4'd0, 1'b0, "R4");
    issue(RD,  2'd0, 4'd2, 1'b0, "R4");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R4");
    issue(RD,  2'd0, 4'd0, 1'b0, "R4 boundary");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R2 no strobe for flagged read");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R2");
    issue(NOP, 2'd0, 4'd0, 1'b1, "R2 strobe at CL");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R2 one cycle");
    issue(ACT, 2'd1, 4'd0, 1'b0, "R4");
    issue(WR,  2'd1, 4'd2, 1'b0, "R4 write");
  endtask

  task automatic t_cl1();
    do_reset();
    cfg_cl = 5'd1;
    issue(ACT, 2'd3, 4'd0, 1'b0, "R2");
    idle(3, "R2");
    issue(RD,  2'd3, 4'd0, 1'b0, "R2");
    issue(NOP, 2'd0, 4'd0, 1'b1, "R2 CL1");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R2 CL1");
    cfg_cl = 5'd3;
  endtask

  task automatic t_tras();
    do_reset();
    issue(ACT, 2'd0, 4'd0, 1'b0, "R5");
    idle(4, "R5");
    issue(PRE, 2'd0, 4'd3, 1'b0, "R5");
    issue(PRE, 2'd0, 4'd0, 1'b0, "R5 boundary");
  endtask

  task automatic t_trc();
    do_reset();
    issue(ACT, 2'd1, 4'd0, 1'b0, "R7");
    idle(4, "R7");
    issue(PRE, 2'd1, 4'd3, 1'b0, "R7");
    idle(2, "R7");
    issue(ACT, 2'd1, 4'd5, 1'b0, "R7 row cycle alone");
  endtask

  task automatic t_trp_prio();
    do_reset();
    issue(ACT, 2'd0, 4'd0, 1'b0, "R6");
    idle(5, "R6");
    issue(PRE, 2'd0, 4'd0, 1'b0, "R6");
    issue(ACT, 2'd0, 4'd4, 1'b0, "R6 R11 lowest code wins");
  endtask

  task automatic t_trp_ok();
    do_reset();
    issue(ACT, 2'd2, 4'd0, 1'b0, "R6");
    idle(5, "R6");
    issue(PRE, 2'd2, 4'd0, 1'b0, "R6");
    idle(2, "R6");
    issue(ACT, 2'd2, 4'd0, 1'b0, "R6 boundary");
  endtask

  task automatic t_trrd();
    do_reset();
    issue(ACT, 2'd0, 4'd0, 1'b0, "R8");
    issue(ACT, 2'd1, 4'd6, 1'b0, "R8");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R8");
    issue(ACT, 2'd2, 4'd0, 1'b0, "R8 boundary");
  endtask

  task automatic t_twr();
    do_reset();
    issue(ACT, 2'd1, 4'd0, 1'b0, "R9");
    idle(2, "R9");
    issue(WR,  2'd1, 4'd0, 1'b0, "R9");
    idle(5, "R9");
    issue(PRE, 2'd1, 4'd7, 1'b0, "R9");
    issue(PRE, 2'd1, 4'd0, 1'b0, "R9 boundary");
  endtask

  task automatic t_twtr();
    do_reset();
    issue(ACT, 2'd0, 4'd0, 1'b0, "R10");
    idle(2, "R10");
    issue(ACT, 2'd1, 4'd0, 1'b0, "R10");
    idle(2, "R10");
    issue(WR,  2'd1, 4'd0, 1'b0, "R10");
    idle(4, "R10");
    issue(RD,  2'd0, 4'd8, 1'b0, "R10 other bank");
    issue(RD,  2'd0, 4'd0, 1'b0, "R10 boundary");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R10");
    issue(NOP, 2'd0, 4'd0, 1'b0, "R2 flagged read silent");
    issue(NOP, 2'd0, 4'd0, 1'b1, "R2");
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_proto();
    t_rcd_cl();
    t_cl1();
    t_tras();
    t_trc();
    t_trp_prio();
    t_trp_ok();
    t_trrd();
    t_twr();
    t_twtr();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule